// File: doc/BRIEF.md
# Half-Bridge Complementary Drive with Dead Time and Brake

This block turns a single PWM reference from a compare channel into two gate-drive signals for one half-bridge. The high-side output follows the reference and the low-side output follows its inverse. At every change of the reference, the side that is switching off drops at once. The side that is switching on waits a programmed number of clock cycles, so both switches are off together for that interval. If the reference changes back before that interval ends, the side that was waiting never turns on for that pulse.

A brake input with selectable polarity and a clock-failure fault input both act as a brake. Either one forces both outputs to configured safe levels at once, through a combinational path with no clock. A synchronised copy of the brake then clears the main output enable and sets a sticky brake flag, which serves as the interrupt request. The outputs stay at the safe levels until software sets the enable again, and software must clear the flag itself.

Top module: `halfbridge_drive`

## Requirements
- R1: After reset, outEnable is 0 and brakeFlag is 0, and outHigh/outLow equal idleHigh/idleLow.
- R2: With deadTime = 0 and the outputs enabled, outHigh equals pwmRef as registered at the last rising edge, and outLow is its inverse.
- R3: With deadTime = D, both outputs go inactive at the first rising edge after a reference change. The incoming side goes active at the (D+1)-th edge, so both are inactive for D cycles.
- R4: While the outputs are enabled and no brake is active, outHigh and outLow are never both 1.
- R5: If the reference changes again before the dead time of the previous change has expired, the incoming side of that previous change never turns on. The countdown then restarts for the new change.
- R6: An active brake forces outHigh = idleHigh and outLow = idleLow in the same cycle, without waiting for a clock edge.
- R7: The third rising edge after the brake becomes active clears outEnable. While outEnable is 0, the outputs hold the idle levels, even after the brake is released. A pulse on moeSet sets outEnable at the next edge, but only when the synchronised brake is inactive; while the brake is held, moeSet has no effect.
- R8: The edge that clears outEnable also sets brakeFlag. brakeFlag stays 1 until a flagClr pulse arrives while no synchronised brake is present. A set in the same cycle as flagClr wins.
- R9: The brake is active when brakeIn equals brakePol: brakePol = 1 means active high and brakePol = 0 means active low.
- R10: clkFail = 1 triggers exactly the same brake action as brakeIn, whatever the setting of brakePol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pwmRef | input | 1 | PWM reference from the compare channel |
| deadTime | input | 8 | Dead time in clock cycles |
| idleHigh | input | 1 | Safe level of the high-side output |
| idleLow | input | 1 | Safe level of the low-side output |
| brakeIn | input | 1 | External brake, asynchronous |
| brakePol | input | 1 | Brake polarity: 1 = active high, 0 = active low |
| clkFail | input | 1 | Clock-failure fault, acts as a brake |
| moeSet | input | 1 | Pulse that sets the main output enable |
| flagClr | input | 1 | Pulse that clears the brake flag |
| outHigh | output | 1 | High-side gate drive |
| outLow | output | 1 | Low-side gate drive |
| outEnable | output | 1 | Main output enable state |
| brakeFlag | output | 1 | Sticky brake flag and interrupt request |

## Verification
Software requests can arrive in the same cycle as the synchronised brake capture. A flag-clear pulse can coincide with the brake setting the flag, and an enable-set pulse can coincide with the brake clearing the enable. The bench provokes both by holding the brake active while it pulses flagClr and, separately, moeSet. It then judges at the ports that brakeFlag stays 1 and outEnable stays 0. Once the brake is released and its synchronised copy has cleared, the same pulses are repeated, and they must now take effect.

// File: rtl/hb_pkg.sv
package hb_pkg;
  // strobes from the guard control to the output datapath
  typedef struct packed {
    logic brakeNow;    // combinational brake, overrides at once
    logic outputsOff;  // main enable is cleared
  } hb_strobe_t;
endpackage

// File: rtl/hb_guard_ctrl.sv
module hb_guard_ctrl
  import hb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       brakeIn,
  input  logic       brakePol,
  input  logic       clkFail,
  input  logic       moeSet,
  input  logic       flagClr,
  output hb_strobe_t strb,
  output logic       outEnable,
  output logic       brakeFlag
);
  localparam int LAST = SYNC_STAGES - 1;

  logic brkAct;
  logic brkSync;
  logic [LAST:0] syncQ;

  assign brkAct = (brakeIn == brakePol) | clkFail;

  generate
    if (SYNC_STAGES < 2) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= brkAct;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[LAST-1:0], brkAct};
      end
    end
  endgenerate

  assign brkSync = syncQ[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outEnable <= 1'b0;
      brakeFlag <= 1'b0;
    end else begin
      if (brkSync)     outEnable <= 1'b0;
      else if (moeSet) outEnable <= 1'b1;
      if (brkSync)      brakeFlag <= 1'b1;
      else if (flagClr) brakeFlag <= 1'b0;
    end
  end

  assign strb.brakeNow   = brkAct;
  assign strb.outputsOff = ~outEnable;
endmodule

// File: rtl/hb_deadband_path.sv
module hb_deadband_path
  import hb_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            pwmRef,
  input  logic [DT_W-1:0] deadTime,
  input  logic            idleHigh,
  input  logic            idleLow,
  input  hb_strobe_t      strb,
  output logic            outHigh,
  output logic            outLow
);
  localparam logic [DT_W-1:0] CNT_ZERO = '0;

  logic            refPrev;
  logic [DT_W-1:0] dtCnt;
  logic            refEdge;
  logic            settled;
  logic            forceSafe;

  assign refEdge = pwmRef ^ refPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPrev <= 1'b0;
      dtCnt   <= CNT_ZERO;
    end else begin
      refPrev <= pwmRef;
      if (refEdge)              dtCnt <= deadTime;
      else if (dtCnt != CNT_ZERO) dtCnt <= dtCnt - 1'b1;
    end
  end

  assign settled   = (dtCnt == CNT_ZERO);
  assign forceSafe = strb.brakeNow | strb.outputsOff;
  assign outHigh   = forceSafe ? idleHigh : (refPrev & settled);
  assign outLow    = forceSafe ? idleLow  : (~refPrev & settled);
endmodule

// File: rtl/halfbridge_drive.sv
module halfbridge_drive
  import hb_pkg::*;
#(
  parameter int DT_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            pwmRef,
  input  logic [DT_W-1:0] deadTime,
  input  logic            idleHigh,
  input  logic            idleLow,
  input  logic            brakeIn,
  input  logic            brakePol,
  input  logic            clkFail,
  input  logic            moeSet,
  input  logic            flagClr,
  output logic            outHigh,
  output logic            outLow,
  output logic            outEnable,
  output logic            brakeFlag
);
  hb_strobe_t strb;

  hb_guard_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .brakeIn(brakeIn), .brakePol(brakePol),
    .clkFail(clkFail), .moeSet(moeSet), .flagClr(flagClr),
    .strb(strb), .outEnable(outEnable), .brakeFlag(brakeFlag)
  );

  hb_deadband_path #(.DT_W(DT_W)) u_path (
    .clk(clk), .rstN(rstN), .pwmRef(pwmRef), .deadTime(deadTime),
    .idleHigh(idleHigh), .idleLow(idleLow), .strb(strb),
    .outHigh(outHigh), .outLow(outLow)
  );
endmodule

// File: rtl/halfbridge_drive_chk.sv
module halfbridge_drive_chk (
  input logic clk,
  input logic rstN,
  input logic idleHigh,
  input logic idleLow,
  input logic brakeIn,
  input logic brakePol,
  input logic clkFail,
  input logic moeSet,
  input logic flagClr,
  input logic outHigh,
  input logic outLow,
  input logic outEnable,
  input logic brakeFlag
);
  logic brkPort;
  assign brkPort = (brakeIn == brakePol) | clkFail;

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outEnable && !brkPort) |-> !(outHigh && outLow));

  p_brake_safe_r6: assert property (@(posedge clk) disable iff (!rstN)
    brkPort |-> (outHigh == idleHigh && outLow == idleLow));

  p_disabled_safe_r7: assert property (@(posedge clk) disable iff (!rstN)
    !outEnable |-> (outHigh == idleHigh && outLow == idleLow));

  p_enable_needs_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!outEnable && !moeSet) |=> !outEnable);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (brakeFlag && !flagClr) |=> brakeFlag);

  p_flag_with_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(brakeFlag) |-> !outEnable);
endmodule

bind halfbridge_drive halfbridge_drive_chk u_chk (
  .clk(clk), .rstN(rstN), .idleHigh(idleHigh), .idleLow(idleLow),
  .brakeIn(brakeIn), .brakePol(brakePol), .clkFail(clkFail),
  .moeSet(moeSet), .flagClr(flagClr), .outHigh(outHigh), .outLow(outLow),
  .outEnable(outEnable), .brakeFlag(brakeFlag)
);

// File: tb/halfbridge_drive_test.sv
`timescale 1ns/1ps
module halfbridge_drive_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwmRef = 1'b0;
  logic [7:0] deadTime = 8'd0;
  logic idleHigh = 1'b0;
  logic idleLow = 1'b1;
  logic brakeIn = 1'b0;
  logic brakePol = 1'b1;
  logic clkFail = 1'b0;
  logic moeSet = 1'b0;
  logic flagClr = 1'b0;
  logic outHigh, outLow, outEnable, brakeFlag;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  halfbridge_drive uut (
    .clk(clk), .rstN(rstN), .pwmRef(pwmRef), .deadTime(deadTime),
    .idleHigh(idleHigh), .idleLow(idleLow), .brakeIn(brakeIn),
    .brakePol(brakePol), .clkFail(clkFail), .moeSet(moeSet),
    .flagClr(flagClr), .outHigh(outHigh), .outLow(outLow),
    .outEnable(outEnable), .brakeFlag(brakeFlag)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkOuts(input string req, input logic h, input logic l);
    #0.5;
    check(outHigh === h && outLow === l, req, {outHigh, outLow}, {h, l});
  endtask

  task automatic enableOutputs();
    moeSet = 1'b1;
    tick();
    moeSet = 1'b0;
  endtask

  // R1: reset state
  task automatic testReset();
    check(outEnable === 1'b0, "R1 enable", outEnable, 0);
    check(brakeFlag === 1'b0, "R1 flag", brakeFlag, 0);
    checkOuts("R1 idle outs", 1'b0, 1'b1);
  endtask

  // R2: no dead time, pure complement
  task automatic testNoDead();
    deadTime = 8'd0;
    pwmRef = 1'b0;
    tick(); tick();
    checkOuts("R2 low steady", 1'b0, 1'b1);
    pwmRef = 1'b1;
    checkOuts("R2 before edge", 1'b0, 1'b1);
    tick();
    checkOuts("R2 high after edge", 1'b1, 1'b0);
    pwmRef = 1'b0;
    tick();
    checkOuts("R2 low after edge", 1'b0, 1'b1);
  endtask

  // R3/R4: dead time D, measure edge where incoming side turns on
  task automatic measureTurnOn(input logic newRef, input int d);
    int n;
    int onAt;
    bit overlap;
    deadTime = d[7:0];
    pwmRef = newRef;
    onAt = 0;
    overlap = 0;
    for (n = 1; n <= d + 3; n++) begin
      tick();
      #0.5;
      if (outHigh && outLow) overlap = 1;
      if (onAt == 0 && (newRef ? outHigh : outLow)) onAt = n;
      if (n <= d) check(!outHigh && !outLow, "R3 gap both off", {outHigh, outLow}, 0);
    end
    check(onAt == d + 1, "R3 turn-on edge", onAt, d + 1);
    check(!overlap, "R4 no overlap", overlap, 0);
  endtask

  task automatic testDead();
    pwmRef = 1'b0;
    deadTime = 8'd0;
    tick(); tick();
    measureTurnOn(1'b1, 3);
    measureTurnOn(1'b0, 3);
    measureTurnOn(1'b1, 7);
    measureTurnOn(1'b0, 1);
  endtask

  // R5: reference pulse shorter than dead time
  task automatic testShortPulse();
    bit sawHigh;
    sawHigh = 0;
    deadTime = 8'd5;
    pwmRef = 1'b0;
    for (int i = 0; i < 8; i++) tick();
    pwmRef = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      #0.5;
      if (outHigh) sawHigh = 1;
    end
    pwmRef = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick();
      #0.5;
      if (outHigh) sawHigh = 1;
      check(!outLow, "R5 low waits restarted gap", outLow, 0);
    end
    check(!sawHigh, "R5 short pulse suppressed", sawHigh, 0);
    tick();
    checkOuts("R5 low back on", 1'b0, 1'b1);
  endtask

  task automatic releaseAndRecover(input string req);
    brakeIn = ~brakePol;
    clkFail = 1'b0;
    for (int i = 0; i < 4; i++) tick();
    checkOuts({req, " stays safe after release"}, idleHigh, idleLow);
    check(outEnable === 1'b0, {req, " enable stays off"}, outEnable, 0);
    flagClr = 1'b1;
    tick();
    flagClr = 1'b0;
    check(brakeFlag === 1'b0, "R8 flag cleared", brakeFlag, 1'b0);
    enableOutputs();
    check(outEnable === 1'b1, "R7 enable set again", outEnable, 1);
  endtask

  // R6/R7/R8: active-high brake with coincident software pulses
  task automatic testBrake();
    deadTime = 8'd0;
    pwmRef = 1'b1;
    idleHigh = 1'b1;
    idleLow = 1'b0;
    tick(); tick();
    checkOuts("R6 driving before brake", 1'b1, 1'b0);
    pwmRef = 1'b0;
    tick();
    checkOuts("R6 driving low", 1'b0, 1'b1);
    brakeIn = 1'b1;
    checkOuts("R6 immediate safe", 1'b1, 1'b0);
    tick(); tick();
    check(outEnable === 1'b1, "R7 enable before third edge", outEnable, 1);
    tick();
    check(outEnable === 1'b0, "R7 enable cleared", outEnable, 0);
    check(brakeFlag === 1'b1, "R8 flag set", brakeFlag, 1);
    moeSet = 1'b1;
    flagClr = 1'b1;
    tick();
    moeSet = 1'b0;
    flagClr = 1'b0;
    check(outEnable === 1'b0, "R7 set ignored under brake", outEnable, 0);
    check(brakeFlag === 1'b1, "R8 clear loses to brake", brakeFlag, 1);
    checkOuts("R7 safe under brake", 1'b1, 1'b0);
    releaseAndRecover("R7");
    #0.5;
    check(outLow === 1'b1 && outHigh === 1'b0, "R7 driving resumes", {outHigh, outLow}, 1);
  endtask

  // R9: active-low polarity
  task automatic testPolarity();
    idleHigh = 1'b0;
    idleLow = 1'b0;
    brakePol = 1'b0;
    brakeIn = 1'b1;
    for (int i = 0; i < 4; i++) tick();
    check(outEnable === 1'b1, "R9 high level inactive", outEnable, 1);
    check(brakeFlag === 1'b0, "R9 no flag", brakeFlag, 0);
    brakeIn = 1'b0;
    checkOuts("R9 low level brakes", 1'b0, 1'b0);
    tick(); tick(); tick();
    check(brakeFlag === 1'b1, "R9 flag set", brakeFlag, 1);
    releaseAndRecover("R9");
  endtask

  // R10: clock-failure fault
  task automatic testClkFail();
    idleHigh = 1'b1;
    idleLow = 1'b1;
    brakePol = 1'b1;
    brakeIn = 1'b0;
    clkFail = 1'b1;
    checkOuts("R10 immediate safe", 1'b1, 1'b1);
    tick(); tick(); tick();
    check(outEnable === 1'b0, "R10 enable cleared", outEnable, 0);
    check(brakeFlag === 1'b1, "R10 flag set", brakeFlag, 1);
    releaseAndRecover("R10");
  endtask

  initial begin
    #3;
    testReset();
    rstN = 1'b1;
    tick();
    testReset();
    enableOutputs();
    check(outEnable === 1'b1, "R7 enable after set", outEnable, 1);
    testNoDead();
    testDead();
    testShortPulse();
    testBrake();
    testPolarity();
    testClkFail();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    failures++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule